// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block puts several requesters in front of one small word-addressed memory and makes sure that every read-modify-write it performs is indivisible. Next to plain reads and writes it offers exchange, test-and-set, fetch-and-increment, and a linked-load / conditional-store pair. For the last pair it keeps one reservation per port. Typical use is lock and counter handling between processor ports that share a scratch memory.

Each port offers a request with a valid/ready handshake. The request carries a 3-bit opcode, a word address and a write value. A round-robin arbiter accepts at most one request per cycle. A read, write, linked load or conditional store responds on the cycle after it is accepted. Exchange, test-and-set and fetch-and-increment hold the memory for a read cycle and then a write cycle, and no request is accepted in between. Responses come back as a one-cycle pulse on the port's own valid line, with the data on a shared bus.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset every word reads as 0, no port holds a reservation, and no response is pending.
- R2: The opcode is 3 bits: 0 read, 1 write, 2 exchange, 3 test-and-set, 4 fetch-and-increment, 5 linked load, 6 conditional store. Opcode 7 acts as a read. A read returns the word. A write stores the write value and returns 0.
- R3: Exchange stores the write value and returns the word's previous contents.
- R4: Test-and-set returns the value it read, and stores 1 only when that value is 0. Otherwise the word is unchanged.
- R5: Fetch-and-increment returns the old value and stores the old value plus one, wrapping modulo 2^DATA_W.
- R6: A linked load returns the word and records a reservation for its port on that address. The new reservation replaces any earlier one from that port. A conditional store whose port holds a reservation on the same address stores the value and returns 1.
- R7: A conditional store returns 0 and leaves memory unchanged in three cases: the port has no reservation, its reservation is for another address, or some completed write to that address (from any port, including the port's own) has come between.
- R8: Writes to other addresses do not cancel a reservation.
- R9: Ports are served round-robin with one grant per cycle. The port after the last one granted has first priority, and port 0 has it after reset.
- R10: A non-atomic request responds in the cycle after the edge that accepts it. An exchange, test-and-set or fetch-and-increment responds one cycle later, and no request is accepted on the edge between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NUM_PORTS | Request valid, one bit per port |
| req_ready | output | NUM_PORTS | Request accepted this cycle, one bit per port |
| req_op | input | 3*NUM_PORTS | Opcode per port, port p at bits [3p+2:3p] |
| req_addr | input | ADDR_W*NUM_PORTS | Word address per port |
| req_wdata | input | DATA_W*NUM_PORTS | Write value per port |
| rsp_valid | output | NUM_PORTS | One-cycle response pulse per port |
| rsp_data | output | DATA_W | Response word for the port pulsing rsp_valid |

## Verification
Two things can land in the same cycle: a conditional store from one port and a plain write to the same word from another. The arbiter then decides whether the reservation is cancelled first. The bench raises both requests on the same edge, with the round-robin pointer placed first on one side and then on the other. It expects the store to succeed and be overwritten in the first case, and to fail while the write survives in the second. A second race sends two exchanges at one lock word. Exactly one of them may see 0, and the loser must be accepted two cycles after the winner.

// File: rtl/amu_pkg.sv
package amu_pkg;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_SWAP    = 3'd2,
        OP_TSET    = 3'd3,
        OP_FINC    = 3'd4,
        OP_LINK    = 3'd5,
        OP_CSTORE  = 3'd6
    } amu_op_e;

    typedef enum logic {
        ST_ISSUE  = 1'b0,
        ST_MODIFY = 1'b1
    } amu_fsm_e;

    function automatic logic is_rmw(logic [2:0] op);
        return (op == 3'(OP_SWAP)) || (op == 3'(OP_TSET)) || (op == 3'(OP_FINC));
    endfunction

endpackage

// File: rtl/amu_rr_arb.sv
module amu_rr_arb #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             advance,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] grant_idx
);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic       found;

    always_comb begin
        st_d      = st_q;
        grant     = '0;
        grant_idx = '0;
        found     = 1'b0;
        for (int i = 0; i < N; i++) begin
            int unsigned k;
            k = (int'(st_q.ptr) + i) % N;
            if (!found && req[k]) begin
                grant[k]  = 1'b1;
                grant_idx = IDX_W'(k);
                found     = 1'b1;
            end
        end
        if (advance && found) begin
            st_d.ptr = (int'(grant_idx) == N - 1) ? '0 : grant_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_grant_from_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|grant));

endmodule

// File: rtl/amu_store.sv
module amu_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[raddr];

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/amu_resv.sv
module amu_resv #(
    parameter int N      = 4,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_port,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic [IDX_W-1:0]  chk_port,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_hit
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } resv_t;

    resv_t resv_d [N];
    resv_t resv_q [N];

    always_comb begin
        for (int p = 0; p < N; p++) begin
            resv_d[p] = resv_q[p];
            if (clr_en && resv_q[p].vld && (resv_q[p].addr == clr_addr)) begin
                resv_d[p].vld = 1'b0;
            end
            if (set_en && (int'(set_port) == p)) begin
                resv_d[p].vld  = 1'b1;
                resv_d[p].addr = set_addr;
            end
        end
        chk_hit = resv_q[chk_port].vld && (resv_q[chk_port].addr == chk_addr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < N; p++) begin
                resv_q[p] <= '0;
            end
        end else begin
            for (int p = 0; p < N; p++) begin
                resv_q[p] <= resv_d[p];
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        p_store_cancels_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && !(set_en && (int'(set_port) == g)))
            |=> !(resv_q[g].vld && (resv_q[g].addr == $past(clr_addr))));

        p_link_records_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (set_en && (int'(set_port) == g))
            |=> (resv_q[g].vld && (resv_q[g].addr == $past(set_addr))));
    end

endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
    import amu_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 16,
    parameter int ADDR_W    = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        req_valid,
    output logic [NUM_PORTS-1:0]        req_ready,
    input  logic [3*NUM_PORTS-1:0]      req_op,
    input  logic [ADDR_W*NUM_PORTS-1:0] req_addr,
    input  logic [DATA_W*NUM_PORTS-1:0] req_wdata,
    output logic [NUM_PORTS-1:0]        rsp_valid,
    output logic [DATA_W-1:0]           rsp_data
);

    localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    typedef struct packed {
        amu_fsm_e              fsm;
        logic [PIDX_W-1:0]     port;
        logic [2:0]            op;
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     wdata;
        logic [DATA_W-1:0]     old;
        logic [NUM_PORTS-1:0]  rsp_vld;
        logic [DATA_W-1:0]     rsp_dat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_PORTS-1:0] arb_req;
    logic [NUM_PORTS-1:0] arb_grant;
    logic [PIDX_W-1:0]    arb_idx;
    logic                 arb_adv;

    logic [2:0]           sel_op;
    logic [ADDR_W-1:0]    sel_addr;
    logic [DATA_W-1:0]    sel_wdata;
    logic                 any_grant;

    logic                 mem_we;
    logic [ADDR_W-1:0]    mem_waddr;
    logic [DATA_W-1:0]    mem_wdata;
    logic [DATA_W-1:0]    mem_rdata;

    logic                 ll_set;
    logic                 resv_hit;

    // Arbitration only while no read-modify-write holds the memory
    assign arb_req   = (ctl_q.fsm == ST_ISSUE) ? req_valid : '0;
    assign req_ready = arb_grant;
    assign any_grant = |arb_grant;

    assign sel_op    = req_op[int'(arb_idx)*3 +: 3];
    assign sel_addr  = req_addr[int'(arb_idx)*ADDR_W +: ADDR_W];
    assign sel_wdata = req_wdata[int'(arb_idx)*DATA_W +: DATA_W];

    amu_rr_arb #(
        .N     (NUM_PORTS),
        .IDX_W (PIDX_W)
    ) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (arb_req),
        .advance   (arb_adv),
        .grant     (arb_grant),
        .grant_idx (arb_idx)
    );

    amu_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (sel_addr),
        .rdata (mem_rdata)
    );

    amu_resv #(
        .N      (NUM_PORTS),
        .ADDR_W (ADDR_W),
        .IDX_W  (PIDX_W)
    ) i_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (ll_set),
        .set_port (arb_idx),
        .set_addr (sel_addr),
        .clr_en   (mem_we),
        .clr_addr (mem_waddr),
        .chk_port (arb_idx),
        .chk_addr (sel_addr),
        .chk_hit  (resv_hit)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.rsp_vld = '0;
        arb_adv       = 1'b0;
        mem_we        = 1'b0;
        mem_waddr     = sel_addr;
        mem_wdata     = sel_wdata;
        ll_set        = 1'b0;

        unique case (ctl_q.fsm)
            ST_ISSUE: begin
                if (any_grant) begin
                    arb_adv       = 1'b1;
                    ctl_d.port    = arb_idx;
                    ctl_d.op      = sel_op;
                    ctl_d.addr    = sel_addr;
                    ctl_d.wdata   = sel_wdata;
                    if (is_rmw(sel_op)) begin
                        ctl_d.old = mem_rdata;
                        ctl_d.fsm = ST_MODIFY;
                    end else begin
                        ctl_d.rsp_vld[arb_idx] = 1'b1;
                        unique case (sel_op)
                            3'(OP_WRITE): begin
                                mem_we        = 1'b1;
                                ctl_d.rsp_dat = '0;
                            end
                            3'(OP_LINK): begin
                                ll_set        = 1'b1;
                                ctl_d.rsp_dat = mem_rdata;
                            end
                            3'(OP_CSTORE): begin
                                mem_we        = resv_hit;
                                ctl_d.rsp_dat = DATA_W'(resv_hit);
                            end
                            default: begin
                                ctl_d.rsp_dat = mem_rdata;
                            end
                        endcase
                    end
                end
            end
            ST_MODIFY: begin
                mem_waddr = ctl_q.addr;
                unique case (ctl_q.op)
                    3'(OP_SWAP): begin
                        mem_we    = 1'b1;
                        mem_wdata = ctl_q.wdata;
                    end
                    3'(OP_TSET): begin
                        mem_we    = (ctl_q.old == '0);
                        mem_wdata = DATA_W'(1);
                    end
                    default: begin
                        mem_we    = 1'b1;
                        mem_wdata = ctl_q.old + 1'b1;
                    end
                endcase
                ctl_d.rsp_vld[ctl_q.port] = 1'b1;
                ctl_d.rsp_dat             = ctl_q.old;
                ctl_d.fsm                 = ST_ISSUE;
            end
            default: ctl_d.fsm = ST_ISSUE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.fsm <= ST_ISSUE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid = ctl_q.rsp_vld;
    assign rsp_data  = ctl_q.rsp_dat;

    p_hold_after_rmw_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (any_grant && is_rmw(sel_op)) |=> (req_ready == '0));

    p_single_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (any_grant && !is_rmw(sel_op)) |=> (rsp_valid == $past(req_ready)));

    p_rmw_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (any_grant && is_rmw(sel_op)) |=> ##1 (rsp_valid == $past(req_ready, 2)));

    p_one_response_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

    p_ready_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_ready & ~req_valid) == '0));

endmodule

// File: tb/test_atomic_mem_unit.sv
module test_atomic_mem_unit;

    localparam int NP = 4;
    localparam int W  = 16;
    localparam int D  = 16;
    localparam int AW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     req_valid;
    logic [NP-1:0]     req_ready;
    logic [3*NP-1:0]   req_op;
    logic [AW*NP-1:0]  req_addr;
    logic [W*NP-1:0]   req_wdata;
    logic [NP-1:0]     rsp_valid;
    logic [W-1:0]      rsp_data;

    logic          pv  [NP];
    logic [2:0]    pop [NP];
    logic [AW-1:0] pad [NP];
    logic [W-1:0]  pwd [NP];

    logic [W-1:0]  res_data [NP];
    int            res_lat  [NP];
    int            res_cyc  [NP];

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            req_valid[p]            = pv[p];
            req_op[p*3 +: 3]        = pop[p];
            req_addr[p*AW +: AW]    = pad[p];
            req_wdata[p*W +: W]     = pwd[p];
        end
    end

    atomic_mem_unit #(
        .NUM_PORTS (NP),
        .DATA_W    (W),
        .DEPTH     (D),
        .ADDR_W    (AW)
    ) i_atomic_mem_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [W-1:0] wd);
        bit r;
        int t;
        @(negedge clk);
        pv[p] = 1'b1; pop[p] = op; pad[p] = a; pwd[p] = wd;
        forever begin
            #1;
            r = req_ready[p];
            res_cyc[p] = cyc;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        @(negedge clk);
        pv[p] = 1'b0;
        t = 0;
        forever begin
            #1;
            if (rsp_valid[p]) begin
                res_data[p] = rsp_data;
                break;
            end
            t++;
            if (t > 20) begin
                res_data[p] = 'x;
                break;
            end
            @(negedge clk);
        end
        res_lat[p] = t;
    endtask

    typedef struct packed {
        logic [1:0]    port;
        logic [2:0]    op;
        logic [AW-1:0] addr;
        logic [W-1:0]  wd;
        logic [W-1:0]  exp;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd0, 4'h3, 16'h0000, 16'h0000},  // R1 reset word
        '{2'd0, 3'd1, 4'h3, 16'h1234, 16'h0000},  // R2 write
        '{2'd1, 3'd0, 4'h3, 16'h0000, 16'h1234},  // R2 read back
        '{2'd1, 3'd2, 4'h3, 16'h00AA, 16'h1234},  // R3 swap old
        '{2'd2, 3'd0, 4'h3, 16'h0000, 16'h00AA},  // R3 swap stored
        '{2'd2, 3'd2, 4'h5, 16'h0001, 16'h0000},  // R3 lock acquired
        '{2'd3, 3'd2, 4'h5, 16'h0001, 16'h0001},  // R3 lock held
        '{2'd0, 3'd3, 4'h6, 16'h0000, 16'h0000},  // R4 set from 0
        '{2'd1, 3'd3, 4'h6, 16'h0000, 16'h0001},  // R4 already set
        '{2'd1, 3'd1, 4'h7, 16'h0005, 16'h0000},  // R2 write
        '{2'd1, 3'd3, 4'h7, 16'h0000, 16'h0005},  // R4 nonzero seen
        '{2'd2, 3'd0, 4'h7, 16'h0000, 16'h0005},  // R4 word untouched
        '{2'd3, 3'd4, 4'h8, 16'h0000, 16'h0000},  // R5 first
        '{2'd3, 3'd4, 4'h8, 16'h0000, 16'h0001},  // R5 second
        '{2'd0, 3'd1, 4'h8, 16'hFFFF, 16'h0000},  // R2 write max
        '{2'd0, 3'd4, 4'h8, 16'h0000, 16'hFFFF},  // R5 at max
        '{2'd0, 3'd0, 4'h8, 16'h0000, 16'h0000},  // R5 wrapped
        '{2'd1, 3'd5, 4'h9, 16'h0000, 16'h0000},  // R6 link
        '{2'd1, 3'd6, 4'h9, 16'h0077, 16'h0001},  // R6 store ok
        '{2'd2, 3'd0, 4'h9, 16'h0000, 16'h0077},  // R6 stored
        '{2'd1, 3'd6, 4'h9, 16'h0088, 16'h0000},  // R7 own store cancelled
        '{2'd2, 3'd0, 4'h9, 16'h0000, 16'h0077},  // R7 unchanged
        '{2'd2, 3'd5, 4'hA, 16'h0000, 16'h0000},  // R6 link p2
        '{2'd3, 3'd5, 4'hA, 16'h0000, 16'h0000},  // R6 link p3
        '{2'd3, 3'd4, 4'hA, 16'h0000, 16'h0000},  // R7 rmw cancels
        '{2'd2, 3'd6, 4'hA, 16'h0055, 16'h0000},  // R7 p2 fails
        '{2'd3, 3'd6, 4'hA, 16'h0066, 16'h0000},  // R7 p3 fails
        '{2'd0, 3'd0, 4'hA, 16'h0000, 16'h0001},  // R7 unchanged
        '{2'd0, 3'd5, 4'hB, 16'h0000, 16'h0000},  // R6 link B
        '{2'd0, 3'd5, 4'hC, 16'h0000, 16'h0000},  // R6 relink C
        '{2'd0, 3'd6, 4'hB, 16'h0009, 16'h0000},  // R7 other address
        '{2'd0, 3'd6, 4'hC, 16'h0009, 16'h0001},  // R6 replaced resv
        '{2'd1, 3'd0, 4'hC, 16'h0000, 16'h0009},  // R6 stored
        '{2'd2, 3'd7, 4'hC, 16'h0000, 16'h0009},  // R2 opcode 7 reads
        '{2'd2, 3'd5, 4'hD, 16'h0000, 16'h0000},  // R6 link D
        '{2'd1, 3'd1, 4'hE, 16'h0003, 16'h0000},  // R8 write elsewhere
        '{2'd2, 3'd6, 4'hD, 16'h0004, 16'h0001},  // R8 resv kept
        '{2'd3, 3'd6, 4'h1, 16'h0002, 16'h0000},  // R1 no reservation
        '{2'd3, 3'd0, 4'h1, 16'h0000, 16'h0000}   // R1 word still 0
    };

    function automatic int exp_lat(input logic [2:0] op);
        return (op == 3'd2 || op == 3'd3 || op == 3'd4) ? 1 : 0;
    endfunction

    initial begin
        for (int p = 0; p < NP; p++) begin
            pv[p] = 1'b0; pop[p] = '0; pad[p] = '0; pwd[p] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid idle", W'(rsp_valid), '0);
        chk("R1 req_ready idle", W'(req_ready), '0);

        for (int i = 0; i < NV; i++) begin
            int p;
            p = int'(VEC[i].port);
            do_op(p, VEC[i].op, VEC[i].addr, VEC[i].wd);
            chk($sformatf("vector %0d data", i), res_data[p], VEC[i].exp);
            chk($sformatf("R10 vector %0d latency", i), W'(res_lat[p]),
                W'(exp_lat(VEC[i].op)));
        end

        // R9: last grant went to port 3, so pointer is 0; move it to 2 via port 1
        do_op(1, 3'd0, 4'h3, '0);
        fork
            do_op(0, 3'd0, 4'h3, '0);
            do_op(1, 3'd0, 4'h3, '0);
            do_op(2, 3'd0, 4'h3, '0);
            do_op(3, 3'd0, 4'h3, '0);
        join
        chk("R9 port3 after port2", W'(res_cyc[3] - res_cyc[2]), W'(1));
        chk("R9 port0 after port2", W'(res_cyc[0] - res_cyc[2]), W'(2));
        chk("R9 port1 after port2", W'(res_cyc[1] - res_cyc[2]), W'(3));

        // R7 race A: conditional store wins arbitration over a write
        do_op(0, 3'd5, 4'h4, '0);
        do_op(3, 3'd0, 4'h4, '0);
        fork
            do_op(0, 3'd6, 4'h4, 16'h0011);
            do_op(1, 3'd1, 4'h4, 16'h0022);
        join
        chk("R7 race A store result", res_data[0], 16'h0001);
        do_op(2, 3'd0, 4'h4, '0);
        chk("R7 race A final word", res_data[2], 16'h0022);

        // R7 race B: write wins arbitration and cancels the reservation
        do_op(1, 3'd5, 4'h2, '0);
        do_op(3, 3'd0, 4'h2, '0);
        fork
            do_op(0, 3'd1, 4'h2, 16'h0033);
            do_op(1, 3'd6, 4'h2, 16'h0044);
        join
        chk("R7 race B store result", res_data[1], 16'h0000);
        chk("R7 race B order", W'(res_cyc[1] - res_cyc[0]), W'(1));
        do_op(0, 3'd0, 4'h2, '0);
        chk("R7 race B final word", res_data[0], 16'h0033);

        // R3/R10 race C: two swaps on one lock word, pointer now at 1
        fork
            do_op(1, 3'd2, 4'h0, 16'h0001);
            do_op(2, 3'd2, 4'h0, 16'h0001);
        join
        chk("R3 race C winner", res_data[1], 16'h0000);
        chk("R3 race C loser", res_data[2], 16'h0001);
        chk("R10 race C hold gap", W'(res_cyc[2] - res_cyc[1]), W'(2));

        // R1: reset clears memory and reservations
        do_op(3, 3'd5, 4'hF, '0);
        do_op(3, 3'd1, 4'h5, 16'h0042);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_op(3, 3'd0, 4'h5, '0);
        chk("R1 word cleared", res_data[3], 16'h0000);
        do_op(3, 3'd6, 4'hF, 16'h0007);
        chk("R1 reservation cleared", res_data[3], 16'h0000);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule